// File: doc/BRIEF.md
# 3x3 Neighbourhood Sum Unit

This block turns a raster stream of 8-bit pixels into a stream of 12-bit sums, one per pixel position, where each sum covers the 3x3 neighbourhood ending at that position. The sum stands in for a local mean, with no division. Pixels arrive under three qualifiers (frame active, line active, pixel present). A pixel is taken only when all three are high on a clock edge.

The work is split into two passes. A two-deep tap register and a three-input adder form a horizontal sum of the current pixel and the two before it. That 10-bit partial sum is written into one of three rotating line banks. In the same cycle, the partial sums at the same column from the two previous rows are read back and added to it. The registered result comes out one clock after the pixel that completes the window. It carries a valid strobe and markers for the first result of a line and of a frame. Only partial sums are stored, not raw pixels. Border positions, where the window is incomplete, give no output.

Top module: `win3x3_sum`

## Requirements
- R1: While reset is asserted and directly after it, `sum_vld`, `sum_sol`, `sum_sof` are 0 and `sum_out` is 0.
- R2: A pixel is accepted only on a clock edge where `frm_vld`, `lin_vld` and `dat_vld` are all 1. Edges without acceptance change no result and produce `sum_vld` = 0 in the next cycle.
- R3: Number accepted pixels in a line from column 0 and lines in a frame from row 0. When the pixel at row r, column c (r>=2, c>=2) is accepted, the next cycle shows `sum_vld` = 1 and `sum_out` equal to the sum of pixels at rows r-2..r and columns c-2..c.
- R4: `sum_vld` stays 0 for pixels in rows 0 and 1 of a frame and in columns 0 and 1 of each line.
- R5: `sum_sol` is 1 exactly with the valid result for column 2. `sum_sof` is 1 exactly with the first valid result of a frame (row 2, column 2). Both are only high together with `sum_vld`.
- R6: When `lin_vld` is low, the column count returns to 0. When `frm_vld` is low, the row count and the bank rotation return to their start, so each frame begins again at row 0.
- R7: An all-255 window gives 2295 without wrap-around.
- R8: Pixels after the first `IMG_W` accepted in a line produce no output and do not disturb stored rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | Frame active qualifier |
| lin_vld | input | 1 | Line active qualifier; goes low between lines |
| dat_vld | input | 1 | Pixel present qualifier |
| pix_in | input | 8 | Pixel value |
| sum_vld | output | 1 | Result valid strobe |
| sum_out | output | 12 | 3x3 neighbourhood sum |
| sum_sol | output | 1 | First result of a line |
| sum_sof | output | 1 | First result of a frame |

## Verification
The checks assume that `lin_vld` drops for at least one cycle between lines and that `frm_vld` drops between frames. They also assume that `lin_vld` falls no later than `frm_vld` at the end of a frame. The stimulus always leaves gaps of two cycles at line and frame ends. It stalls only through `dat_vld` inside a line, so the column count is never cut short by a glitch on `lin_vld`. Frames of varying height run back to back, lines are over-long on purpose, and some images are saturated.

// File: rtl/win3_pkg.sv
package win3_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned HSUM_W = PIX_W + 2;   // three pixels
  localparam int unsigned WSUM_W = PIX_W + 4;   // nine pixels
  localparam int unsigned NBANK  = 3;
endpackage

// File: rtl/win3_ctrl.sv
module win3_ctrl #(
  parameter int unsigned IMG_W = 512,
  parameter int unsigned COL_W = $clog2(IMG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_vld,
  input  logic             lin_vld,
  input  logic             dat_vld,
  output logic             acc,
  output logic [COL_W-1:0] col,
  output logic             rows_ok,
  output logic [1:0]       wsel,
  output logic [1:0]       rsel_a,
  output logic [1:0]       rsel_b
);
  logic [COL_W-1:0] col_q, col_d;
  logic [1:0]       row_q, row_d;
  logic [1:0]       wsel_q, wsel_d;
  logic             lin_q;
  logic             line_end;

  always_comb begin
    acc      = frm_vld && lin_vld && dat_vld && (col_q < COL_W'(IMG_W));
    line_end = lin_q && !lin_vld;
    col_d    = col_q;
    if (!lin_vld)  col_d = '0;
    else if (acc)  col_d = col_q + 1'b1;
    row_d  = row_q;
    wsel_d = wsel_q;
    if (!frm_vld) begin
      row_d  = '0;
      wsel_d = '0;
    end else if (line_end) begin
      if (row_q != 2'd2) row_d = row_q + 1'b1;
      wsel_d = (wsel_q == 2'd2) ? 2'd0 : wsel_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      wsel_q <= '0;
      lin_q  <= 1'b0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      wsel_q <= wsel_d;
      lin_q  <= lin_vld;
    end
  end

  always_comb begin
    col     = col_q;
    rows_ok = (row_q == 2'd2);
    wsel    = wsel_q;
    unique case (wsel_q)
      2'd0:    begin rsel_a = 2'd2; rsel_b = 2'd1; end
      2'd1:    begin rsel_a = 2'd0; rsel_b = 2'd2; end
      default: begin rsel_a = 2'd1; rsel_b = 2'd0; end
    endcase
  end

  // R8: column count never runs past the image width
  p_col_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(IMG_W));
  // R6: a low line qualifier restarts the column count
  p_line_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_vld |=> col_q == '0);
  // R6: a low frame qualifier restarts row count and rotation
  p_rot_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> (wsel_q == 2'd0 && row_q == 2'd0));
endmodule

// File: rtl/win3_hsum.sv
module win3_hsum
  import win3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [PIX_W-1:0]  pix,
  output logic [HSUM_W-1:0] hsum
);
  logic [PIX_W-1:0] t1_q, t2_q, t1_d, t2_d;

  always_comb begin
    t1_d = t1_q;
    t2_d = t2_q;
    if (acc) begin
      t1_d = pix;
      t2_d = t1_q;
    end
    hsum = HSUM_W'(pix) + HSUM_W'(t1_q) + HSUM_W'(t2_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q <= '0;
      t2_q <= '0;
    end else begin
      t1_q <= t1_d;
      t2_q <= t2_d;
    end
  end
endmodule

// File: rtl/win3_linebuf.sv
module win3_linebuf
  import win3_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        wsel,
  input  logic [AW-1:0]     addr,
  input  logic [HSUM_W-1:0] wdata,
  input  logic [1:0]        rsel_a,
  input  logic [1:0]        rsel_b,
  output logic [HSUM_W-1:0] rdata_a,
  output logic [HSUM_W-1:0] rdata_b
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [HSUM_W-1:0] bank_rd [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [HSUM_W-1:0] mem [DEPTH];
    logic              bank_we;
    assign bank_we = we && (wsel == 2'(g));
    always_ff @(posedge clk) begin
      if (bank_we) mem[addr] <= wdata;
    end
    assign bank_rd[g] = mem[addr];
  end

  always_comb begin
    unique case (rsel_a)
      2'd0:    rdata_a = bank_rd[0];
      2'd1:    rdata_a = bank_rd[1];
      default: rdata_a = bank_rd[2];
    endcase
    unique case (rsel_b)
      2'd0:    rdata_b = bank_rd[0];
      2'd1:    rdata_b = bank_rd[1];
      default: rdata_b = bank_rd[2];
    endcase
  end
endmodule

// File: rtl/win3x3_sum.sv
module win3x3_sum
  import win3_pkg::*;
#(
  parameter int unsigned IMG_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic              lin_vld,
  input  logic              dat_vld,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              sum_vld,
  output logic [WSUM_W-1:0] sum_out,
  output logic              sum_sol,
  output logic              sum_sof
);
  localparam int unsigned COL_W = $clog2(IMG_W + 1);
  localparam int unsigned AW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic             acc, rows_ok;
  logic [COL_W-1:0] col;
  logic [1:0]       wsel, rsel_a, rsel_b;
  logic [HSUM_W-1:0] hsum, rd_a, rd_b;

  win3_ctrl #(.IMG_W(IMG_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .lin_vld(lin_vld),
    .dat_vld(dat_vld), .acc(acc), .col(col), .rows_ok(rows_ok),
    .wsel(wsel), .rsel_a(rsel_a), .rsel_b(rsel_b)
  );

  win3_hsum u_hsum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .pix(pix_in), .hsum(hsum)
  );

  win3_linebuf #(.AW(AW)) u_lbuf (
    .clk(clk), .we(acc), .wsel(wsel), .addr(col[AW-1:0]), .wdata(hsum),
    .rsel_a(rsel_a), .rsel_b(rsel_b), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  logic              vld_q, vld_d, sol_q, sol_d, sof_q, sof_d, pend_q, pend_d;
  logic [WSUM_W-1:0] sum_q, sum_d;

  always_comb begin
    vld_d = acc && rows_ok && (col >= COL_W'(2));
    sum_d = sum_q;
    if (vld_d) sum_d = WSUM_W'(hsum) + WSUM_W'(rd_a) + WSUM_W'(rd_b);
    sol_d  = vld_d && (col == COL_W'(2));
    sof_d  = sol_d && pend_q;
    pend_d = pend_q;
    if (!frm_vld)   pend_d = 1'b1;
    else if (vld_d) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sum_q  <= '0;
      sol_q  <= 1'b0;
      sof_q  <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      vld_q  <= vld_d;
      sum_q  <= sum_d;
      sol_q  <= sol_d;
      sof_q  <= sof_d;
      pend_q <= pend_d;
    end
  end

  assign sum_vld = vld_q;
  assign sum_out = sum_q;
  assign sum_sol = sol_q;
  assign sum_sof = sof_q;

  // R2: a cycle without all three qualifiers yields no result
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_vld && lin_vld && dat_vld) |=> !sum_vld);
  // R5: markers only accompany a valid result
  p_sol_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_sol |-> sum_vld);
  p_sof_sol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_sof |-> sum_sol);
endmodule

// File: tb/tb_win3x3_sum.sv
`timescale 1ns/1ps
module tb_win3x3_sum;
  localparam int W    = 8;
  localparam int MAXR = 8;

  logic clk = 1'b0;
  logic rst_n, frm_vld, lin_vld, dat_vld;
  logic [7:0]  pix_in;
  logic        sum_vld, sum_sol, sum_sof;
  logic [11:0] sum_out;

  always #2 clk = ~clk;

  win3x3_sum #(.IMG_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .lin_vld(lin_vld),
    .dat_vld(dat_vld), .pix_in(pix_in), .sum_vld(sum_vld),
    .sum_out(sum_out), .sum_sol(sum_sol), .sum_sof(sum_sof)
  );

  int nchk = 0, nerr = 0;
  int img [MAXR][W];
  bit e_vld = 0, e_sol = 0, e_sof = 0;
  int e_sum = 0;
  string e_tag = "R1 reset";
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int win_sum(int r, int c);
    int s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += img[r-i][c-j];
    return s;
  endfunction

  // one clock: check last cycle's expectation, then drive new inputs
  task automatic drive(bit f, bit l, bit d, logic [7:0] p, int r, int c, string tag);
    bit a;
    @(negedge clk);
    chk({e_tag, " valid"}, int'(sum_vld), int'(e_vld));
    if (e_vld) chk({e_tag, " sum"}, int'(sum_out), e_sum);
    chk("R5 line marker", int'(sum_sol), int'(e_sol));
    chk("R5 frame marker", int'(sum_sof), int'(e_sof));
    frm_vld = f; lin_vld = l; dat_vld = d; pix_in = p;
    a = f && l && d && (c < W);
    if (a) img[r][c] = int'(p);
    e_vld = a && r >= 2 && c >= 2;
    e_sum = e_vld ? win_sum(r, c) : 0;
    e_sol = e_vld && c == 2;
    e_sof = e_sol && r == 2;
    e_tag = tag;
  endtask

  task automatic run_frame(int h, int mode, int extra, int fidx);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < W + extra; c++) begin
        string tag;
        logic [7:0] p;
        while ($urandom % 4 == 0)
          drive(1, 1, 0, 8'($urandom), r, c, "R2 stall");
        p = (mode == 1) ? 8'd255 : 8'($urandom);
        if (c >= W)                 tag = "R8 excess";
        else if (mode == 1)         tag = "R7 saturation";
        else if (fidx > 0 && r < 2) tag = "R6 restart";
        else if (r < 2 || c < 2)    tag = "R4 border";
        else                        tag = "R3 window";
        drive(1, 1, 1, p, r, c, tag);
      end
      drive(1, 0, 1'($urandom), 8'($urandom), r, 0, "R6 line gap");
      drive(1, 0, 0, 8'($urandom), r, 0, "R6 line gap");
    end
    drive(0, 0, 0, 8'd0, 0, 0, "R6 frame gap");
    drive(0, 1, 1, 8'($urandom), 0, 0, "R2 frame low");
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; frm_vld = 0; lin_vld = 0; dat_vld = 0; pix_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(sum_vld), 0);
    chk("R1 reset sum", int'(sum_out), 0);
    chk("R1 reset markers", int'(sum_sol) + int'(sum_sof), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", int'(sum_vld), 0);
    run_frame(5, 0, 0, 0);   // random content with stalls
    run_frame(4, 1, 0, 1);   // saturated image
    run_frame(4, 0, 3, 2);   // over-long lines
    run_frame(2, 0, 0, 3);   // too short for any output
    for (int k = 0; k < 4; k++)
      run_frame(3 + int'($urandom % 4), 0, int'($urandom % 2), 4 + k);
    drive(0, 0, 0, 8'd0, 0, 0, "R2 idle");
    drive(0, 0, 0, 8'd0, 0, 0, "R2 idle");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule